// File: doc/BRIEF.md
# Virtual-Channel Allocation Output Selector

When a router's output-VC arbiters have resolved, a single input virtual channel can hold several output port and VC pairs at once. This block settles that. It scans the winner table, which records for every output port and VC which input VC won it, and gives each requesting input VC exactly one of its winnings. The one kept is the entry with the largest downstream credit count. Every other entry that the same input had won is flagged for release, so the allocator can hand those output VCs to other inputs on a later cycle.

The selection is combinational over the whole table. The result is registered and appears one clock after the table is presented with its strobe. Cycles without the strobe produce an all-clear result. The selected port and VC fields then keep their last values.

Top module: `vc_out_select`

## Requirements
- R1: While reset is asserted and right after it is released, every bit of `sel_vld`, `keep_o` and `squash_o` is 0.
- R2: A table presented with `tbl_vld` high at a clock edge produces its result on the outputs from that edge on. After an edge where `tbl_vld` is low, `sel_vld`, `keep_o` and `squash_o` are all zero.
- R3: Entry `a` of the table stands for output port `a / NVC` and output VC `a % NVC`. Input VC `v` of input port `p` has flat index `p*NVC + v`. That input owns entry `a` when `win_vld[a]` is 1 and `win_idx` field `a` equals the input's flat index.
- R4: A requesting input that owns one or more entries gets `sel_vld` set. Its `sel_port` and `sel_vc` name the owned entry with the strictly highest downstream credit count.
- R5: When several owned entries share the highest non-zero credit count, the entry with the lowest index is chosen.
- R6: When every owned entry has a credit count of zero, the owned entry with the lowest index is chosen.
- R7: Every entry chosen by some input has its `keep_o` bit set. Every other owned entry of a requesting input has its `squash_o` bit set. No entry has both bits set, and no entry is chosen by two inputs.
- R8: An input whose `req_mask` bit is 0 gets `sel_vld` 0. The entries it owns have neither `keep_o` nor `squash_o` set.
- R9: A requesting input that owns no entry gets `sel_vld` 0, so it stays pending and can retry on a later table.
- R10: `sel_port` and `sel_vc` keep their values across any clock edge where `tbl_vld` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_vld | input | 1 | Winner table and side inputs are valid this cycle |
| win_vld | input | NOUT | Per output VC entry: an input VC won it |
| win_idx | input | NOUT*IDXW | Per entry: flat index of the winning input VC |
| dn_credit | input | NOUT*CRW | Per entry: downstream credit count of that output VC |
| req_mask | input | NIN | Per input VC: input is in the VC-requested state |
| sel_vld | output | NIN | Per input VC: a selection was made |
| sel_port | output | NIN*PW | Per input VC: selected output port |
| sel_vc | output | NIN*VW | Per input VC: selected output VC |
| keep_o | output | NOUT | Per entry: entry is kept by its winner |
| squash_o | output | NOUT | Per entry: entry is released because its winner chose another |

## Verification
A wrong credit comparison or tie rule shows up at the ports on the clock after the faulty table as a mismatched `sel_port`/`sel_vc` pair. The same error also moves a `keep_o` bit onto an entry that should carry `squash_o`. A wrong owner decode shows as a `sel_vld` bit on a non-owning or idle input, or as an output VC kept twice, in that same cycle. A missing clear or enable on the result registers shows one idle cycle later as stale valid, keep or squash bits, or as changed port fields.

// File: rtl/vcsel_pkg.sv
package vcsel_pkg;

  // Field width for an index over n items, never less than one bit.
  function automatic int wbits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/vcsel_pick.sv
// Chooses one owned table entry for a single input VC.
module vcsel_pick #(
  parameter int NOUT   = 10,
  parameter int NVC    = 2,
  parameter int IDXW   = 4,
  parameter int CRW    = 4,
  parameter int PW     = 3,
  parameter int VW     = 1,
  parameter int MY_IDX = 0
) (
  input  logic                 req,
  input  logic [NOUT-1:0]      win_vld,
  input  logic [NOUT*IDXW-1:0] win_idx,
  input  logic [NOUT*CRW-1:0]  dn_credit,
  output logic                 pick_vld,
  output logic [NOUT-1:0]      pick_oh,
  output logic [PW-1:0]        pick_port,
  output logic [VW-1:0]        pick_vc
);

  logic [NOUT-1:0] own;
  logic [NOUT-1:0] first_oh;
  logic [NOUT-1:0] best_oh;
  logic [CRW-1:0]  best_cr;
  logic            have_first;
  logic            have_best;

  // Ownership per entry.
  always_comb begin
    for (int a = 0; a < NOUT; a++) begin
      own[a] = req && win_vld[a] && (win_idx[a*IDXW +: IDXW] == IDXW'(MY_IDX));
    end
  end

  // Ordered scan: strictly greater credit replaces, so ties keep the lower
  // index; the first owned entry is kept as a fallback.
  always_comb begin
    first_oh   = '0;
    best_oh    = '0;
    best_cr    = '0;
    have_first = 1'b0;
    have_best  = 1'b0;
    for (int a = 0; a < NOUT; a++) begin
      if (own[a] && !have_first) begin
        first_oh[a] = 1'b1;
        have_first  = 1'b1;
      end
      if (own[a] && (dn_credit[a*CRW +: CRW] > best_cr)) begin
        best_oh    = '0;
        best_oh[a] = 1'b1;
        best_cr    = dn_credit[a*CRW +: CRW];
        have_best  = 1'b1;
      end
    end
  end

  assign pick_vld = have_first;
  assign pick_oh  = have_best ? best_oh : first_oh;

  // Decode the chosen entry into port and VC.
  always_comb begin
    pick_port = '0;
    pick_vc   = '0;
    for (int a = 0; a < NOUT; a++) begin
      if (pick_oh[a]) begin
        pick_port = PW'(a / NVC);
        pick_vc   = VW'(a % NVC);
      end
    end
  end

endmodule

// File: rtl/vcsel_release.sv
// Per table entry: kept by its winner, or released because the winner
// settled on a different entry.
module vcsel_release #(
  parameter int NIN  = 10,
  parameter int NOUT = 10,
  parameter int IDXW = 4
) (
  input  logic [NOUT-1:0]      win_vld,
  input  logic [NOUT*IDXW-1:0] win_idx,
  input  logic [NIN-1:0]       req_mask,
  input  logic [NIN*NOUT-1:0]  pick_oh_all,
  output logic [NOUT-1:0]      keep_c,
  output logic [NOUT-1:0]      squash_c
);

  logic [NOUT-1:0] owner_req;

  always_comb begin
    keep_c    = '0;
    owner_req = '0;
    for (int a = 0; a < NOUT; a++) begin
      for (int i = 0; i < NIN; i++) begin
        keep_c[a] = keep_c[a] | pick_oh_all[i*NOUT + a];
        if (win_idx[a*IDXW +: IDXW] == IDXW'(i)) begin
          owner_req[a] = req_mask[i];
        end
      end
    end
  end

  assign squash_c = win_vld & owner_req & ~keep_c;

endmodule

// File: rtl/vc_out_select.sv
module vc_out_select #(
  parameter int NPORT = 5,
  parameter int NVC   = 2,
  parameter int CRW   = 4,
  localparam int NIN  = NPORT * NVC,
  localparam int NOUT = NPORT * NVC,
  localparam int IDXW = vcsel_pkg::wbits(NIN),
  localparam int PW   = vcsel_pkg::wbits(NPORT),
  localparam int VW   = vcsel_pkg::wbits(NVC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tbl_vld,
  input  logic [NOUT-1:0]      win_vld,
  input  logic [NOUT*IDXW-1:0] win_idx,
  input  logic [NOUT*CRW-1:0]  dn_credit,
  input  logic [NIN-1:0]       req_mask,
  output logic [NIN-1:0]       sel_vld,
  output logic [NIN*PW-1:0]    sel_port,
  output logic [NIN*VW-1:0]    sel_vc,
  output logic [NOUT-1:0]      keep_o,
  output logic [NOUT-1:0]      squash_o
);

  logic [NIN-1:0]      pick_vld_all;
  logic [NIN*NOUT-1:0] pick_oh_all;
  logic [NIN*PW-1:0]   pick_port_all;
  logic [NIN*VW-1:0]   pick_vc_all;
  logic [NOUT-1:0]     keep_c;
  logic [NOUT-1:0]     squash_c;

  // One selector per input VC.
  for (genvar g = 0; g < NIN; g++) begin : g_pick
    vcsel_pick #(
      .NOUT(NOUT), .NVC(NVC), .IDXW(IDXW), .CRW(CRW),
      .PW(PW), .VW(VW), .MY_IDX(g)
    ) u_pick (
      .req       (req_mask[g]),
      .win_vld   (win_vld),
      .win_idx   (win_idx),
      .dn_credit (dn_credit),
      .pick_vld  (pick_vld_all[g]),
      .pick_oh   (pick_oh_all[g*NOUT +: NOUT]),
      .pick_port (pick_port_all[g*PW +: PW]),
      .pick_vc   (pick_vc_all[g*VW +: VW])
    );
  end

  vcsel_release #(.NIN(NIN), .NOUT(NOUT), .IDXW(IDXW)) u_release (
    .win_vld     (win_vld),
    .win_idx     (win_idx),
    .req_mask    (req_mask),
    .pick_oh_all (pick_oh_all),
    .keep_c      (keep_c),
    .squash_c    (squash_c)
  );

  // Next state: flags pulse for one cycle per presented table.
  logic [NIN-1:0]  vld_d;
  logic [NOUT-1:0] keep_d;
  logic [NOUT-1:0] squash_d;
  logic            fld_en;

  always_comb begin
    vld_d    = tbl_vld ? pick_vld_all : '0;
    keep_d   = tbl_vld ? keep_c       : '0;
    squash_d = tbl_vld ? squash_c     : '0;
    fld_en   = tbl_vld;
  end

  logic [NIN-1:0]    vld_q;
  logic [NIN*PW-1:0] port_q;
  logic [NIN*VW-1:0] vc_q;
  logic [NOUT-1:0]   keep_q;
  logic [NOUT-1:0]   squash_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= '0;
      keep_q   <= '0;
      squash_q <= '0;
      port_q   <= '0;
      vc_q     <= '0;
    end else begin
      vld_q    <= vld_d;
      keep_q   <= keep_d;
      squash_q <= squash_d;
      if (fld_en) begin
        port_q <= pick_port_all;
        vc_q   <= pick_vc_all;
      end
    end
  end

  assign sel_vld  = vld_q;
  assign sel_port = port_q;
  assign sel_vc   = vc_q;
  assign keep_o   = keep_q;
  assign squash_o = squash_q;

endmodule

// File: rtl/vcsel_chk.sv
module vcsel_chk #(
  parameter int NIN  = 10,
  parameter int NOUT = 10,
  parameter int PW   = 3,
  parameter int VW   = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tbl_vld,
  input logic [NIN-1:0]    req_mask,
  input logic [NIN-1:0]    sel_vld,
  input logic [NIN*PW-1:0] sel_port,
  input logic [NIN*VW-1:0] sel_vc,
  input logic [NOUT-1:0]   keep_o,
  input logic [NOUT-1:0]   squash_o
);

  // R2
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tbl_vld |=> (sel_vld == '0) && (keep_o == '0) && (squash_o == '0));

  // R10
  field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tbl_vld |=> $stable(sel_port) && $stable(sel_vc));

  // R7
  keep_squash_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (keep_o & squash_o) == '0);

  // R7
  one_keep_per_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(keep_o) == $countones(sel_vld));

  // R8
  idle_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_vld |=> (sel_vld & ~$past(req_mask)) == '0);

endmodule

bind vc_out_select vcsel_chk #(.NIN(NIN), .NOUT(NOUT), .PW(PW), .VW(VW)) u_vcsel_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tbl_vld  (tbl_vld),
  .req_mask (req_mask),
  .sel_vld  (sel_vld),
  .sel_port (sel_port),
  .sel_vc   (sel_vc),
  .keep_o   (keep_o),
  .squash_o (squash_o)
);

// File: tb/vc_out_select_bench.sv
`timescale 1ns/1ps
module vc_out_select_bench;

  localparam int NPORT = 5;
  localparam int NVC   = 2;
  localparam int CRW   = 4;
  localparam int NIN   = NPORT * NVC;
  localparam int NOUT  = NPORT * NVC;
  localparam int IDXW  = 4;
  localparam int PW    = 3;
  localparam int VW    = 1;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 tbl_vld;
  logic [NOUT-1:0]      win_vld;
  logic [NOUT*IDXW-1:0] win_idx;
  logic [NOUT*CRW-1:0]  dn_credit;
  logic [NIN-1:0]       req_mask;
  logic [NIN-1:0]       sel_vld;
  logic [NIN*PW-1:0]    sel_port;
  logic [NIN*VW-1:0]    sel_vc;
  logic [NOUT-1:0]      keep_o;
  logic [NOUT-1:0]      squash_o;

  vc_out_select #(.NPORT(NPORT), .NVC(NVC), .CRW(CRW)) u_vc_out_select (
    .clk(clk), .rst_n(rst_n), .tbl_vld(tbl_vld), .win_vld(win_vld),
    .win_idx(win_idx), .dn_credit(dn_credit), .req_mask(req_mask),
    .sel_vld(sel_vld), .sel_port(sel_port), .sel_vc(sel_vc),
    .keep_o(keep_o), .squash_o(squash_o)
  );

  always #5 clk = ~clk;

  bit wv[NOUT];
  int widx[NOUT];
  int cr[NOUT];
  bit rq[NIN];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [NIN*PW-1:0] last_port;
  logic [NIN*VW-1:0] last_vc;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_tbl();
    for (int a = 0; a < NOUT; a++) begin wv[a] = 0; widx[a] = 0; cr[a] = 0; end
    for (int i = 0; i < NIN; i++) rq[i] = 0;
  endtask

  task automatic drive(input bit v);
    for (int a = 0; a < NOUT; a++) begin
      win_vld[a]                = wv[a];
      win_idx[a*IDXW +: IDXW]   = IDXW'(widx[a]);
      dn_credit[a*CRW +: CRW]   = CRW'(cr[a]);
    end
    for (int i = 0; i < NIN; i++) req_mask[i] = rq[i];
    tbl_vld = v;
  endtask

  function automatic int exp_ent(input int i);
    int first = -1;
    int best  = -1;
    int bc    = 0;
    if (!rq[i]) return -1;
    for (int a = 0; a < NOUT; a++) begin
      if (wv[a] && widx[a] == i) begin
        if (first < 0) first = a;
        if (cr[a] > bc) begin bc = cr[a]; best = a; end
      end
    end
    return (best >= 0) ? best : first;
  endfunction

  task automatic randomize_tbl();
    for (int a = 0; a < NOUT; a++) begin
      wv[a]   = ($urandom % 4) != 0;
      widx[a] = $urandom % NIN;
      cr[a]   = ($urandom % 2) ? ($urandom % 3) : ($urandom % 16);
    end
    for (int i = 0; i < NIN; i++) rq[i] = ($urandom % 3) != 0;
  endtask

  // Present the table, check the registered result, then one idle cycle.
  task automatic run_case(input string tag);
    logic [NOUT-1:0] ekeep;
    logic [NOUT-1:0] esq;
    int seen[NOUT];
    @(negedge clk);
    drive(1'b1);
    @(negedge clk);
    ekeep = '0;
    for (int a = 0; a < NOUT; a++) seen[a] = 0;
    for (int i = 0; i < NIN; i++) begin
      int e = exp_ent(i);
      chk(sel_vld[i] == (e >= 0), tag, $sformatf("sel_vld[%0d]", i),
          int'(sel_vld[i]), int'(e >= 0));
      if (e >= 0) begin
        ekeep[e] = 1'b1;
        chk(int'(sel_port[i*PW +: PW]) == e / NVC, tag,
            $sformatf("sel_port[%0d]", i), int'(sel_port[i*PW +: PW]), e / NVC);
        chk(int'(sel_vc[i*VW +: VW]) == e % NVC, tag,
            $sformatf("sel_vc[%0d]", i), int'(sel_vc[i*VW +: VW]), e % NVC);
      end
      if (sel_vld[i]) begin
        int k = int'(sel_port[i*PW +: PW]) * NVC + int'(sel_vc[i*VW +: VW]);
        if (k < NOUT) seen[k]++;
      end
    end
    for (int a = 0; a < NOUT; a++) begin
      esq[a] = wv[a] && rq[widx[a]] && !ekeep[a];
      // R7: an output VC may go to at most one input VC
      chk(seen[a] <= 1, "R7", $sformatf("owners of entry %0d", a), seen[a], 1);
    end
    chk(keep_o == ekeep, tag, "keep_o", int'(keep_o), int'(ekeep));
    chk(squash_o == esq, tag, "squash_o", int'(squash_o), int'(esq));
    last_port = sel_port;
    last_vc   = sel_vc;
    randomize_tbl();
    drive(1'b0);
    @(negedge clk);
    // R2: idle edge clears flags; R10: fields hold
    chk(sel_vld == '0, "R2", "sel_vld idle", int'(sel_vld), 0);
    chk(keep_o == '0 && squash_o == '0, "R2", "keep/squash idle",
        int'(keep_o | squash_o), 0);
    chk(sel_port == last_port, "R10", "sel_port hold", int'(sel_port), int'(last_port));
    chk(sel_vc == last_vc, "R10", "sel_vc hold", int'(sel_vc), int'(last_vc));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd7731);
    rst_n = 1'b0;
    clear_tbl();
    drive(1'b0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sel_vld == '0 && keep_o == '0 && squash_o == '0, "R1", "flags in reset",
        int'(sel_vld | keep_o | squash_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sel_vld == '0 && keep_o == '0 && squash_o == '0, "R1", "flags after release",
        int'(sel_vld | keep_o | squash_o), 0);

    // R3: input 7 (port 3, vc 1) owns entry 4 only -> port 2, vc 0
    clear_tbl();
    wv[4] = 1; widx[4] = 7; cr[4] = 5; rq[7] = 1;
    run_case("R3");

    // R4: input 2 owns entries 1(3), 5(9), 8(6) -> entry 5
    clear_tbl();
    wv[1] = 1; widx[1] = 2; cr[1] = 3;
    wv[5] = 1; widx[5] = 2; cr[5] = 9;
    wv[8] = 1; widx[8] = 2; cr[8] = 6;
    rq[2] = 1;
    run_case("R4");

    // R5: input 0 owns entries 3(7), 6(7), 9(2) -> entry 3
    clear_tbl();
    wv[3] = 1; widx[3] = 0; cr[3] = 7;
    wv[6] = 1; widx[6] = 0; cr[6] = 7;
    wv[9] = 1; widx[9] = 0; cr[9] = 2;
    rq[0] = 1;
    run_case("R5");

    // R6: input 4 owns entries 2, 7, 9 all at zero credit -> entry 2
    clear_tbl();
    wv[2] = 1; widx[2] = 4;
    wv[7] = 1; widx[7] = 4;
    wv[9] = 1; widx[9] = 4;
    rq[4] = 1;
    run_case("R6");

    // R8: input 1 not requesting owns entries 0, 1; input 3 requests entry 6
    clear_tbl();
    wv[0] = 1; widx[0] = 1; cr[0] = 4;
    wv[1] = 1; widx[1] = 1; cr[1] = 8;
    wv[6] = 1; widx[6] = 3; cr[6] = 1;
    rq[3] = 1;
    run_case("R8");

    // R9: input 6 requests but owns nothing
    clear_tbl();
    wv[5] = 1; widx[5] = 2; cr[5] = 3;
    rq[6] = 1; rq[2] = 1;
    run_case("R9");

    // R4 under random tables, ties and zero credits frequent
    for (int n = 0; n < 300; n++) begin
      randomize_tbl();
      run_case("R4");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule